// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a group of general-purpose pins and turns level transitions on them into interrupts. Every pin has two independent enables, one for rising transitions and one for falling transitions, so each pin can be armed for rising only, falling only, both directions, or nothing at all. The pin level is brought into the module clock domain by a two-flop synchronizer, and one further register stage holds the previous level so that a transition shows up as a difference between two adjacent samples.

Software changes the enables through strobe registers. Writing a one to a bit of a "turn on" register arms that pin, and writing a one to a bit of the matching "turn off" register disarms it. Bits written as zero leave the enable unchanged, so no read-modify-write is needed. A pending register latches every qualifying transition until software writes a one to that bit. Each pin also has its own one-cycle interrupt pulse, and a single bank interrupt stays high while any pending bit is set. The level that is watched is the pad output value when the pin is driven as an output. This lets software raise an interrupt by toggling its own output, which is useful for testing the interrupt path.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset all rising enables, falling enables and pending bits read as zero, and `pin_irq_o` and `bank_irq_o` are low.
- R2: A write to address 0 sets the rising enable of every pin whose data bit is 1. Rising enables of pins whose data bit is 0 keep their value.
- R3: A write to address 1 clears the rising enable of every pin whose data bit is 1. Other pins keep their value.
- R4: A write to address 2 sets falling enables and a write to address 3 clears them, in both cases for the pins whose data bit is 1. Other pins keep their value.
- R5: A read of address 0 or 1 returns the rising enables, a read of address 2 or 3 returns the falling enables, a read of address 4 returns the pending bits, and a read of any other address returns zero.
- R6: A 0-to-1 change of a pin's watched level with its rising enable set gives a one-cycle high pulse on that pin's `pin_irq_o` bit and sets its pending bit. Both happen at the third rising clock edge after the level change.
- R7: A 1-to-0 change with the falling enable set behaves the same way and has the same latency.
- R8: A pin with both enables set reports transitions in both directions. A pin with both enables clear reports no transition and its pending bit stays zero.
- R9: The watched level is `pin_out_i` when `pin_dir_i` is 1 and `pin_in_i` when it is 0. The input that is not selected has no effect.
- R10: A write to address 4 clears the pending bits whose data bit is 1. Data bits of 0 leave pending bits unchanged.
- R11: If a qualifying transition and a write-one clear of the same pending bit fall on the same clock edge, the bit stays set.
- R12: `bank_irq_o` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in_i | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out_i | input | NUM_PINS | Pad output values driven by the GPIO output logic |
| pin_dir_i | input | NUM_PINS | Per pin 1 = output, 0 = input |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | NUM_PINS | Register write data |
| reg_rdata_o | output | NUM_PINS | Register read data, combinational from address |
| pin_irq_o | output | NUM_PINS | Per-pin one-cycle interrupt pulses |
| bank_irq_o | output | 1 | OR of all pending bits |

## Verification
A level change driven just after clock edge N reaches the first synchronizer flop at N+1 and the compare stage at N+2. The per-pin pulse and the pending bit are registered at N+3. The bench driver therefore queues each expected pulse vector tagged with cycle N+3, and the monitor compares `pin_irq_o` against the queue at every falling edge, so it also flags pulses that arrive early, late or on a pin that was never armed. Register writes take effect at the next edge, so readbacks and bank checks are made only after several idle cycles. The same-edge case is built by placing the pending-clear write so that it is sampled on edge N+3 itself.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_RISE_ON  = 3'd0,
    RA_RISE_OFF = 3'd1,
    RA_FALL_ON  = 3'd2,
    RA_FALL_OFF = 3'd3,
    RA_PEND     = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN_W-2:0], lvl_i[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign cur_o[p]  = chain_q[SYNC_STAGES-1];
    assign prev_o[p] = chain_q[SYNC_STAGES];
  end

endmodule

// File: rtl/gpio_edge_en_regs.sv
module gpio_edge_en_regs #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] rise_set_i,
  input  logic [NUM_PINS-1:0] rise_clr_i,
  input  logic [NUM_PINS-1:0] fall_set_i,
  input  logic [NUM_PINS-1:0] fall_clr_i,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o
);

  logic [NUM_PINS-1:0] rise_q, rise_d;
  logic [NUM_PINS-1:0] fall_q, fall_d;
  logic                rise_upd, fall_upd;

  always_comb begin
    rise_upd = |(rise_set_i | rise_clr_i);
    fall_upd = |(fall_set_i | fall_clr_i);
    rise_d   = (rise_q | rise_set_i) & ~rise_clr_i;
    fall_d   = (fall_q | fall_set_i) & ~fall_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (rise_upd) rise_q <= rise_d;
      if (fall_upd) fall_q <= fall_d;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

endmodule

// File: rtl/gpio_pend_regs.sv
module gpio_pend_regs #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] pulse_o
);

  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] pulse_q;
  logic                pend_upd;

  always_comb begin
    pend_upd = |(hit_i | clr_i);
    pend_d   = (pend_q & ~clr_i) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pulse_q <= '0;
    end else begin
      if (pend_upd) pend_q <= pend_d;
      pulse_q <= hit_i;
    end
  end

  assign pend_o  = pend_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  input  logic [NUM_PINS-1:0]   pin_out_i,
  input  logic [NUM_PINS-1:0]   pin_dir_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_PINS-1:0]   reg_wdata_i,
  output logic [NUM_PINS-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0]   pin_irq_o,
  output logic                  bank_irq_o
);

  localparam int unsigned RST_STAGES = 2;

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] watch_lvl;
  logic [NUM_PINS-1:0] lvl_cur, lvl_prev;
  logic [NUM_PINS-1:0] rise_en, fall_en;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] rise_set, rise_clr, fall_set, fall_clr, pend_clr;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    watch_lvl = (pin_out_i & pin_dir_i) | (pin_in_i & ~pin_dir_i);
  end

  gpio_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (watch_lvl),
    .cur_o  (lvl_cur),
    .prev_o (lvl_prev)
  );

  always_comb begin
    rise_set = '0;
    rise_clr = '0;
    fall_set = '0;
    fall_clr = '0;
    pend_clr = '0;
    if (reg_we_i) begin
      case (reg_addr_i)
        RA_RISE_ON:  rise_set = reg_wdata_i;
        RA_RISE_OFF: rise_clr = reg_wdata_i;
        RA_FALL_ON:  fall_set = reg_wdata_i;
        RA_FALL_OFF: fall_clr = reg_wdata_i;
        RA_PEND:     pend_clr = reg_wdata_i;
        default:     ;
      endcase
    end
  end

  gpio_edge_en_regs #(.NUM_PINS(NUM_PINS)) u_en (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rise_set_i (rise_set),
    .rise_clr_i (rise_clr),
    .fall_set_i (fall_set),
    .fall_clr_i (fall_clr),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en)
  );

  always_comb begin
    hit = (lvl_cur & ~lvl_prev & rise_en) | (~lvl_cur & lvl_prev & fall_en);
  end

  gpio_pend_regs #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit_i   (hit),
    .clr_i   (pend_clr),
    .pend_o  (pend),
    .pulse_o (pin_irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      RA_RISE_ON, RA_RISE_OFF: reg_rdata_o = rise_en;
      RA_FALL_ON, RA_FALL_OFF: reg_rdata_o = fall_en;
      RA_PEND:                 reg_rdata_o = pend;
      default:                 reg_rdata_o = '0;
    endcase
  end

  assign bank_irq_o = |pend;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [NUM_PINS-1:0]   reg_wdata_i,
  input logic [NUM_PINS-1:0]   rise_en,
  input logic [NUM_PINS-1:0]   fall_en,
  input logic [NUM_PINS-1:0]   pend,
  input logic [NUM_PINS-1:0]   pin_irq_o,
  input logic                  bank_irq_o
);

  p_set_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == RA_RISE_ON) |=> ((rise_en & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  p_clr_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == RA_RISE_OFF) |=> ((rise_en & $past(reg_wdata_i)) == '0));

  p_set_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == RA_FALL_ON) |=> ((fall_en & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  p_clr_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == RA_FALL_OFF) |=> ((fall_en & $past(reg_wdata_i)) == '0));

  // R6, R11: a pulse always leaves its pending bit set, even under a same-edge clear
  p_pulse_marks_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_irq_o & ~pend) == '0));

  p_pulse_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_irq_o) |-> ((pin_irq_o & ~($past(rise_en) | $past(fall_en))) == '0));

  p_pend_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> $past(reg_we_i && reg_addr_i == RA_PEND));

  p_pend_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == RA_PEND) |=> (($past(pend) & ~$past(reg_wdata_i) & ~pend) == '0));

  p_bank_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_irq_o) |-> $past(reg_we_i && reg_addr_i == RA_PEND));

endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .rise_en     (rise_en),
  .fall_en     (fall_en),
  .pend        (pend),
  .pin_irq_o   (pin_irq_o),
  .bank_irq_o  (bank_irq_o)
);

// File: tb/gpio_edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_ctrl_tb_top;

  localparam int N = 8;

  typedef struct {
    int          due;
    logic [N-1:0] vec;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_in, pin_out, pin_dir;
  logic         we;
  logic [2:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic [N-1:0] pin_irq;
  logic         bank_irq;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit mon_on = 1'b0;

  exp_t exp_q[$];
  logic [N-1:0] m_rise, m_fall, m_pend, m_lvl;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_edge_irq_ctrl #(.NUM_PINS(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in_i    (pin_in),
    .pin_out_i   (pin_out),
    .pin_dir_i   (pin_dir),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_irq_o   (pin_irq),
    .bank_irq_o  (bank_irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops queued pulse vectors at their due cycle, expects silence otherwise
  logic [N-1:0] mon_exp;
  bit           mon_hit;
  always @(negedge clk) begin
    if (mon_on) begin
      mon_exp = '0;
      mon_hit = 1'b0;
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        mon_exp = exp_q[0].vec;
        void'(exp_q.pop_front());
        mon_hit = 1'b1;
      end
      if (mon_hit || pin_irq !== '0) check("R6/R7/R8 pulse", pin_irq, mon_exp);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    case (a)
      3'd0: m_rise = m_rise | d;
      3'd1: m_rise = m_rise & ~d;
      3'd2: m_fall = m_fall | d;
      3'd3: m_fall = m_fall & ~d;
      3'd4: m_pend = m_pend & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  // driver: sets pad signals and pushes the expected pulse vector, due three edges later
  task automatic drive(input logic [N-1:0] pi, input logic [N-1:0] po, input logic [N-1:0] pd);
    logic [N-1:0] eff, e;
    exp_t it;
    @(negedge clk);
    pin_in = pi; pin_out = po; pin_dir = pd;
    eff = (po & pd) | (pi & ~pd);
    e = (eff & ~m_lvl & m_rise) | (~eff & m_lvl & m_fall);
    m_lvl = eff;
    if (e != '0) begin
      it.due = cyc + 3;
      it.vec = e;
      exp_q.push_back(it);
      m_pend = m_pend | e;
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pin_in = '0; pin_out = '0; pin_dir = '0;
    m_rise = '0; m_fall = '0; m_pend = '0; m_lvl = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1
    check("R1 pin_irq", pin_irq, '0);
    check("R1 bank", {7'd0, bank_irq}, '0);
    for (int a = 0; a < 5; a++) rd("R1 regs", 3'(a), '0);

    // R2, R5
    wr(3'd0, 8'h0F);
    rd("R2 set rise", 3'd0, 8'h0F);
    rd("R5 rise via addr1", 3'd1, 8'h0F);
    wr(3'd0, 8'h30);
    rd("R2 zeros keep", 3'd0, 8'h3F);
    // R3
    wr(3'd1, 8'h03);
    rd("R3 clr rise", 3'd0, 8'h3C);
    // R4
    wr(3'd2, 8'hF0);
    rd("R4 set fall", 3'd2, 8'hF0);
    wr(3'd3, 8'h80);
    rd("R4 clr fall", 3'd3, 8'h70);
    rd("R4 rise untouched", 3'd1, 8'h3C);
    // R5 unmapped
    rd("R5 addr5", 3'd5, '0);
    rd("R5 addr7", 3'd7, '0);

    // R6: rising on all pins
    drive(8'hFF, 8'h00, 8'h00);
    idle(5);
    rd("R6 pend", 3'd4, m_pend);
    check("R12 bank set", {7'd0, bank_irq}, 8'd1);
    // R7: falling on all pins
    drive(8'h00, 8'h00, 8'h00);
    idle(5);
    rd("R7 pend", 3'd4, m_pend);

    // R10
    wr(3'd4, 8'h0C);
    rd("R10 clear ones", 3'd4, m_pend);
    wr(3'd4, 8'h00);
    rd("R10 zero no effect", 3'd4, m_pend);
    wr(3'd4, 8'hFF);
    rd("R10 clear all", 3'd4, '0);
    idle(1);
    check("R12 bank clear", {7'd0, bank_irq}, '0);

    // R8: pins 0 and 7 have neither enable
    drive(8'h81, 8'h00, 8'h00);
    idle(2);
    drive(8'h00, 8'h00, 8'h00);
    idle(5);
    rd("R8 neither mode", 3'd4, '0);
    // R8: both-edge pin 4 toggled twice
    drive(8'h10, 8'h00, 8'h00);
    idle(2);
    drive(8'h00, 8'h00, 8'h00);
    idle(5);
    rd("R8 both mode pend", 3'd4, 8'h10);
    wr(3'd4, 8'hFF);

    // R9: pin 4 as output; pad output drives, pad input ignored
    drive(8'h00, 8'h00, 8'h10);
    idle(2);
    drive(8'h00, 8'h10, 8'h10);
    idle(5);
    rd("R9 output level seen", 3'd4, 8'h10);
    wr(3'd4, 8'hFF);
    drive(8'h00, 8'h10, 8'h10);
    drive(8'h10, 8'h10, 8'h10);
    idle(2);
    drive(8'h00, 8'h10, 8'h10);
    idle(5);
    rd("R9 input ignored", 3'd4, '0);
    drive(8'h00, 8'h00, 8'h00);
    idle(5);
    wr(3'd4, 8'hFF);
    rd("R9 pend cleared", 3'd4, '0);

    // R11: rising pin 2 lands on the same edge as a clear of pin 2
    drive(8'h04, 8'h00, 8'h00);
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 3'd4; wdata = 8'h04;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    idle(3);
    rd("R11 set wins", 3'd4, 8'h04);
    check("R11 bank", {7'd0, bank_irq}, 8'd1);

    idle(3);
    check("scoreboard drained", 8'(exp_q.size()), '0);
    summary();
  end

endmodule